// File: doc/BRIEF.md
# Latched Trap Vector Generator

This block sits next to an opcode trap that turns reserved opcodes into a break. While the processor fetches an opcode whose two lowest bits are both 1, the block stores the upper six bits of that byte as a code index and raises a pending flag. When the processor then reads its interrupt vector from the top two bytes of memory, the block replaces the memory data with a handler address chosen for that code. Each trapped code therefore lands in its own handler and no software has to decode the opcode again.

The handler address comes from one of two sources, picked by a parameter. In table mode a writable store holds two bytes for each of the 64 codes. In generated mode the address is a programmable 16-bit base plus the code index times 16, so the entry points sit 16 bytes apart. Once the high vector byte has been read, the pending flag drops. A later hardware interrupt that has no trap behind it then reads the normal memory vector.

Top module: `trap_vector_gen`

## Requirements
- R1: After reset the valid flag is 0, and a read of 0xFFFE or 0xFFFF returns the read data unchanged.
- R2: A read with the fetch strobe high and data bits 1..0 equal to 2'b11 latches the code index (data bits 7..2) and sets the valid flag on the next cycle. A fetch whose low bits are anything else leaves the flag at 0.
- R3: In table mode, while valid, a read of 0xFFFE returns table entry index*2.
- R4: In table mode, while valid, a read of 0xFFFF returns table entry index*2+1.
- R5: A read of 0xFFFF while valid clears the flag on the next cycle. After that, reads of 0xFFFE and 0xFFFF pass the memory data through.
- R6: While valid, a read of 0xFFFE leaves the flag set, and reads of any other address return the read data unchanged.
- R7: A new trap replaces the latched code, so the vector bytes that follow belong to the newest code.
- R8: In generated mode the vector is base + index*16. Writing the port at address 0 sets the low byte of the base and writing it at address 1 sets the high byte. 0xFFFE returns the low byte of the sum and 0xFFFF returns the high byte.
- R9: A table write takes effect at the clock edge, and a vector read in any later cycle returns the new value.
- R10: A read that has data bits 1..0 equal to 2'b11 but the fetch strobe low does not set the valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Processor address bus |
| rdEn | input | 1 | Processor read strobe |
| fetch | input | 1 | High during an opcode fetch |
| rdData | input | 8 | Data returned by memory for the current read |
| wrEn | input | 1 | Table or base write enable |
| wrAddr | input | 7 | Table entry, or base byte select in generated mode |
| wrData | input | 8 | Write data |
| outData | output | 8 | Data delivered to the processor |
| outValid | output | 1 | A trapped code is waiting for its vector read |

## Verification
The hardest state to reach is a trap that overwrites a pending code before its vector is read. The bench issues two trap fetches back to back with no vector read between them and then checks that both bytes belong to the second code. A second hard case is a pending trap that must survive a low-byte read and reads of other addresses. The stimulus reads 0xFFFE twice and an ordinary address before it reads 0xFFFF. It then makes a vector read with no trap behind it and checks that the memory data passes through. A second instance built in generated mode gets the same bus traffic, so both address sources are checked on identical trap sequences.

// File: rtl/tvg_pkg.sv
package tvg_pkg;
  typedef struct packed {
    logic latchEn;
    logic clearEn;
    logic selLo;
    logic selHi;
  } tvg_strobe_t;
endpackage

// File: rtl/tvg_ctrl.sv
module tvg_ctrl
  import tvg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int TRAP_BITS = 2,
  parameter logic [ADDR_W-1:0] VEC_LO_ADDR = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              fetch,
  input  logic [TRAP_BITS-1:0] rdLow,
  output tvg_strobe_t       strobe,
  output logic              pending
);
  localparam logic [ADDR_W-1:0] VEC_HI_ADDR = VEC_LO_ADDR + ADDR_W'(1);

  logic hitLo, hitHi, trapHit;

  always_comb begin
    hitLo   = rdEn && (addr == VEC_LO_ADDR);
    hitHi   = rdEn && (addr == VEC_HI_ADDR);
    trapHit = fetch && rdEn && (&rdLow);
    strobe.latchEn = trapHit;
    strobe.clearEn = hitHi && pending && !trapHit;
    strobe.selLo   = hitLo && pending;
    strobe.selHi   = hitHi && pending;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               pending <= 1'b0;
    else if (strobe.latchEn) pending <= 1'b1;
    else if (strobe.clearEn) pending <= 1'b0;
  end
endmodule

// File: rtl/tvg_datapath.sv
module tvg_datapath
  import tvg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int TRAP_BITS = 2,
  parameter int SPACING_LOG2 = 4,
  parameter bit GEN_MODE = 1'b0,
  localparam int CODE_W = DATA_W - TRAP_BITS,
  localparam int TBL_AW = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  tvg_strobe_t       strobe,
  input  logic [DATA_W-1:0] rdData,
  input  logic              wrEn,
  input  logic [TBL_AW-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] outData
);
  localparam int DEPTH = 2 ** TBL_AW;

  logic [CODE_W-1:0] code;
  logic [DATA_W-1:0] vecLo, vecHi;

  always_ff @(posedge clk) begin
    if (!rstN)               code <= '0;
    else if (strobe.latchEn) code <= rdData[DATA_W-1:TRAP_BITS];
  end

  generate
    if (GEN_MODE) begin : g_gen
      logic [ADDR_W-1:0] base;
      logic [ADDR_W-1:0] vec;
      logic baseWr;
      assign baseWr = wrEn && (wrAddr[TBL_AW-1:1] == '0);
      always_ff @(posedge clk) begin
        if (!rstN) base <= '0;
        else if (baseWr) begin
          if (wrAddr[0]) base[ADDR_W-1:DATA_W] <= wrData;
          else           base[DATA_W-1:0]      <= wrData;
        end
      end
      assign vec   = base + (ADDR_W'(code) << SPACING_LOG2);
      assign vecLo = vec[DATA_W-1:0];
      assign vecHi = vec[ADDR_W-1:DATA_W];
    end else begin : g_tbl
      logic [DATA_W-1:0] tbl [DEPTH];
      always_ff @(posedge clk) begin
        if (wrEn) tbl[wrAddr] <= wrData;
      end
      assign vecLo = tbl[{code, 1'b0}];
      assign vecHi = tbl[{code, 1'b1}];
    end
  endgenerate

  always_comb begin
    if (strobe.selLo)      outData = vecLo;
    else if (strobe.selHi) outData = vecHi;
    else                   outData = rdData;
  end
endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
  import tvg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int TRAP_BITS = 2,
  parameter int SPACING_LOG2 = 4,
  parameter bit GEN_MODE = 1'b0,
  parameter logic [ADDR_W-1:0] VEC_LO_ADDR = 16'hFFFE,
  localparam int TBL_AW = DATA_W - TRAP_BITS + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              fetch,
  input  logic [DATA_W-1:0] rdData,
  input  logic              wrEn,
  input  logic [TBL_AW-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] outData,
  output logic              outValid
);
  tvg_strobe_t strobe;

  tvg_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRAP_BITS(TRAP_BITS), .VEC_LO_ADDR(VEC_LO_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .fetch(fetch),
    .rdLow(rdData[TRAP_BITS-1:0]), .strobe(strobe), .pending(outValid)
  );

  tvg_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRAP_BITS(TRAP_BITS),
    .SPACING_LOG2(SPACING_LOG2), .GEN_MODE(GEN_MODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .outData(outData)
  );
endmodule

// File: rtl/tvg_checker.sv
module tvg_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int TRAP_BITS = 2,
  parameter logic [ADDR_W-1:0] VEC_LO_ADDR = 16'hFFFE
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              rdEn,
  input logic              fetch,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] outData,
  input logic              outValid
);
  logic trapIn, vecRead, hiRead;
  assign trapIn  = fetch && rdEn && (&rdData[TRAP_BITS-1:0]);
  assign hiRead  = rdEn && (addr == VEC_LO_ADDR + ADDR_W'(1));
  assign vecRead = rdEn && ((addr == VEC_LO_ADDR) || hiRead);

  assert_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    trapIn |=> outValid);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && hiRead && !trapIn) |=> !outValid);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !hiRead) |=> outValid);

  assert_pass_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(vecRead && outValid) |-> (outData == rdData));

  assert_noset_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && !trapIn) |=> !outValid);
endmodule

bind trap_vector_gen tvg_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRAP_BITS(TRAP_BITS), .VEC_LO_ADDR(VEC_LO_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .fetch(fetch),
  .rdData(rdData), .outData(outData), .outValid(outValid)
);

// File: tb/trap_vector_gen_bench.sv
`timescale 1ns/100ps
module trap_vector_gen_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] addr = '0;
  logic rdEn = 1'b0, fetch = 1'b0;
  logic [7:0] rdData = '0;
  logic wrEn = 1'b0, genWrEn = 1'b0;
  logic [6:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] outData, genData;
  logic outValid, genValid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [15:0] BASE = 16'hC140;
  localparam int NV = 8;
  localparam logic [7:0] OPS [NV] = '{8'h03, 8'hFF, 8'h7B, 8'h47, 8'h87, 8'hC3, 8'h2F, 8'hB7};

  always #2.5 clk = ~clk;

  trap_vector_gen u_trap_vector_gen (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .fetch(fetch), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .outData(outData), .outValid(outValid)
  );

  trap_vector_gen #(.GEN_MODE(1'b1)) u_trap_vector_gen_gen (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .fetch(fetch), .rdData(rdData),
    .wrEn(genWrEn), .wrAddr(wrAddr), .wrData(wrData), .outData(genData), .outValid(genValid)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  function automatic logic [15:0] genVec(input logic [7:0] op);
    return BASE + (16'(op >> 2) << 4);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic rd, input logic f, input logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = rd; fetch = f; rdData = d;
    wrEn = 1'b0; genWrEn = 1'b0;
    #1;
  endtask

  task automatic twrite(input logic g, input logic [6:0] wa, input logic [7:0] wd);
    @(negedge clk);
    addr = 16'h0000; rdEn = 1'b0; fetch = 1'b0;
    wrAddr = wa; wrData = wd; wrEn = !g; genWrEn = g;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(16'hFFFE, 1'b1, 1'b0, 8'h5A);
    check("R1 valid in reset", 16'(outValid), 16'h0);
    check("R1 pass in reset", 16'(outData), 16'h005A);
    step(16'hFFFF, 1'b1, 1'b0, 8'hA6);
    @(negedge clk); rstN = 1'b1;
    step(16'hFFFF, 1'b1, 1'b0, 8'hA6);
    check("R1 pass after reset", 16'(outData), 16'h00A6);
    check("R1 valid after reset", 16'(outValid), 16'h0);

    for (int i = 0; i < 128; i++) twrite(1'b0, 7'(i), pat(i));
    twrite(1'b1, 7'd0, BASE[7:0]);
    twrite(1'b1, 7'd1, BASE[15:8]);

    // R3 R4 R5 R8: vector table walk
    for (int k = 0; k < NV; k++) begin
      int idx;
      idx = int'(OPS[k] >> 2);
      step(16'h0200 + 16'(k), 1'b1, 1'b1, OPS[k]);
      step(16'hFFFE, 1'b1, 1'b0, 8'h11);
      check("R2 valid set", 16'(outValid), 16'h1);
      check("R3 low byte", 16'(outData), 16'(pat(idx * 2)));
      check("R8 gen low byte", 16'(genData), 16'(genVec(OPS[k]) & 16'h00FF));
      step(16'hFFFF, 1'b1, 1'b0, 8'h22);
      check("R4 high byte", 16'(outData), 16'(pat(idx * 2 + 1)));
      check("R8 gen high byte", 16'(genData), 16'(genVec(OPS[k]) >> 8));
      step(16'h0000, 1'b0, 1'b0, 8'h00);
      check("R5 valid cleared", 16'(outValid), 16'h0);
      step(16'hFFFE, 1'b1, 1'b0, 8'h3C);
      check("R5 pass low", 16'(outData), 16'h003C);
      check("R5 gen pass low", 16'(genData), 16'h003C);
      step(16'hFFFF, 1'b1, 1'b0, 8'hC3);
      check("R5 pass high", 16'(outData), 16'h00C3);
    end

    // R2: fetch with other low bits does not trap
    step(16'h0300, 1'b1, 1'b1, 8'h02);
    step(16'h0000, 1'b0, 1'b0, 8'h00);
    check("R2 no trap on 2'b10", 16'(outValid), 16'h0);
    // R10: data read with 2'b11 but no fetch
    step(16'h0400, 1'b1, 1'b0, 8'hFF);
    step(16'hFFFE, 1'b1, 1'b0, 8'h77);
    check("R10 valid stays low", 16'(outValid), 16'h0);
    check("R10 pass through", 16'(outData), 16'h0077);

    // R7: overwrite pending code
    step(16'h0500, 1'b1, 1'b1, 8'h13);
    step(16'h0501, 1'b1, 1'b1, 8'hA7);
    step(16'hFFFE, 1'b1, 1'b0, 8'h00);
    check("R7 low byte newest", 16'(outData), 16'(pat(41 * 2)));
    check("R7 gen low newest", 16'(genData), 16'(genVec(8'hA7) & 16'h00FF));
    // R6: low read keeps pending, other address passes
    step(16'hFFFE, 1'b1, 1'b0, 8'h00);
    check("R6 valid after low read", 16'(outValid), 16'h1);
    step(16'h1234, 1'b1, 1'b0, 8'h9E);
    check("R6 other address pass", 16'(outData), 16'h009E);
    step(16'hFFFF, 1'b1, 1'b0, 8'h00);
    check("R7 high byte newest", 16'(outData), 16'(pat(41 * 2 + 1)));
    step(16'h0000, 1'b0, 1'b0, 8'h00);
    check("R5 cleared after R7", 16'(outValid), 16'h0);

    // R9: table rewrite visible on next read
    twrite(1'b0, 7'd10, 8'hE1);
    step(16'h0600, 1'b1, 1'b1, 8'h17);
    step(16'hFFFE, 1'b1, 1'b0, 8'h00);
    check("R9 rewritten entry", 16'(outData), 16'h00E1);
    step(16'hFFFF, 1'b1, 1'b0, 8'h00);
    check("R9 untouched neighbour", 16'(outData), 16'(pat(11)));
    step(16'h0000, 1'b0, 1'b0, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule